// File: doc/BRIEF.md
# Lock-Qualified Derived-Clock Reset Generator

This block produces the reset for a clock domain whose clock comes from an on-chip frequency synthesizer. It watches three fault sources: the synthesizer lock flag, a status bit that reports the synthesizer's input clock has stopped, and an external reset request. While any of them is active, the domain reset is held active. When a fault appears, the reset asserts at once, without waiting for a derived-clock edge. This matters because the derived clock may itself be missing at that moment.

Release is synchronous to the derived clock. When every fault clears, zeros enter a preset shift chain. A final flip-flop drives the domain reset from the OR of all chain stages, so the reset drops exactly `HOLD_EDGES` rising edges after the source became healthy. Any fault during that hold-off presets the chain again, and the full count starts over. A ready output, the inverse of the registered reset, tells downstream logic that the domain may run.

Top module: `lockq_rst_gen`

## Requirements
- R1: While `lock_i` is 0, `rst_dom_o` is 1.
- R2: While `clk_stopped_i` is 1, `rst_dom_o` is 1, even when `lock_i` reads 1.
- R3: While `ext_rst_req_i` is 1, `rst_dom_o` is 1. A request pulse shorter than one clock period, which crosses no rising edge, still gives a full hold-off of `HOLD_EDGES` edges.
- R4: Reset assertion is asynchronous. `rst_dom_o` becomes 1 within 0.1 ns of a fault appearing, with no rising edge of `clk_dom` in between. This holds even when `clk_dom` is stopped.
- R5: Once every fault input is clear, `rst_dom_o` stays 1 through the first `HOLD_EDGES - 1` rising edges of `clk_dom` and goes to 0 at edge number `HOLD_EDGES` (default 4, minimum 2, checked at elaboration).
- R6: If any fault reappears during the hold-off, even for less than one clock period, the count restarts. Reset then drops only at the `HOLD_EDGES`-th edge after that fault clears.
- R7: `rst_dom_o` is driven directly by a flip-flop, and `dom_ready_o` is always its inverse. When the domain is ready, every stage of the hold-off chain is clear.
- R8: With `clk_dom` stopped, `rst_dom_o` stays 1 once asserted, even after all faults clear. Release needs clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_dom | input | 1 | Derived clock from the synthesizer; clocks the release path |
| lock_i | input | 1 | Synthesizer lock flag, 1 = locked |
| clk_stopped_i | input | 1 | Synthesizer input-clock-stopped status, 1 = stopped |
| ext_rst_req_i | input | 1 | External reset request, active high, any length |
| rst_dom_o | output | 1 | Domain reset, active high, asynchronous assert, synchronous release |
| dom_ready_o | output | 1 | Domain ready, 1 when reset is released |

## Verification
The asynchronous preset and the synchronous shift can meet in the same clock period. This happens when a fault pulse arrives in the middle of the hold-off, just after an edge has already advanced the chain. The bench provokes it by pulsing `lock_i` low for half a nanosecond after two release edges. It judges the result in two ways: the reset must be high before the next edge, and release must then take a full `HOLD_EDGES` edges counted from the pulse, not from the first clearing. The same collision is provoked with the clock stopped, where the preset must act with no edge at all.

// File: rtl/rg_pkg.sv
`timescale 1ns/100ps
package rg_pkg;

   // Width of a counter that must reach the value n.
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   // Smallest hold-off the chain structure supports.
   localparam int MIN_HOLD = 2;

endpackage

// File: rtl/rg_fault_merge.sv
`timescale 1ns/100ps
module rg_fault_merge (
   input  logic lock_i,
   input  logic stopped_i,
   input  logic req_i,
   output logic fault_o
);

   // One active-high preset from all unhealthy conditions.
   assign fault_o = req_i | ~lock_i | stopped_i;

endmodule

// File: rtl/rg_stretch_chain.sv
`timescale 1ns/100ps
module rg_stretch_chain #(
   parameter int STAGES = 3
) (
   input  logic              clk,
   input  logic              preset,
   output logic [STAGES-1:0] taps_o
);

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         logic stg;
         if (i == 0) begin : g_head
            always_ff @(posedge clk or posedge preset) begin
               if (preset) stg <= 1'b1;
               else        stg <= 1'b0;
            end
         end else begin : g_body
            always_ff @(posedge clk or posedge preset) begin
               if (preset) stg <= 1'b1;
               else        stg <= g_stage[i-1].stg;
            end
         end
         assign taps_o[i] = stg;
      end
   endgenerate

endmodule

// File: rtl/rg_out_flop.sv
`timescale 1ns/100ps
module rg_out_flop #(
   parameter int TAPS = 3
) (
   input  logic            clk,
   input  logic            preset,
   input  logic [TAPS-1:0] taps_i,
   output logic            rst_q
);

   always_ff @(posedge clk or posedge preset) begin
      if (preset) rst_q <= 1'b1;
      else        rst_q <= |taps_i;
   end

endmodule

// File: rtl/lockq_rst_gen.sv
`timescale 1ns/100ps
module lockq_rst_gen #(
   parameter int HOLD_EDGES = 4
) (
   input  logic clk_dom,
   input  logic lock_i,
   input  logic clk_stopped_i,
   input  logic ext_rst_req_i,
   output logic rst_dom_o,
   output logic dom_ready_o
);

   import rg_pkg::*;

   localparam int CHAIN_LEN = HOLD_EDGES - 1;
   localparam int CW        = cnt_width(HOLD_EDGES);
   localparam logic [CW-1:0] HOLD_C = CW'(HOLD_EDGES);

   generate
      if (HOLD_EDGES < MIN_HOLD) begin : g_bad_hold
         $error("lockq_rst_gen: HOLD_EDGES must be at least 2");
      end
   endgenerate

   logic                 fault;
   logic [CHAIN_LEN-1:0] taps;
   logic                 rst_q;

   rg_fault_merge u_merge (
      .lock_i    (lock_i),
      .stopped_i (clk_stopped_i),
      .req_i     (ext_rst_req_i),
      .fault_o   (fault)
   );

   rg_stretch_chain #(.STAGES(CHAIN_LEN)) u_chain (
      .clk    (clk_dom),
      .preset (fault),
      .taps_o (taps)
   );

   rg_out_flop #(.TAPS(CHAIN_LEN)) u_out (
      .clk    (clk_dom),
      .preset (fault),
      .taps_i (taps),
      .rst_q  (rst_q)
   );

   assign rst_dom_o   = rst_q;
   assign dom_ready_o = ~rst_q;

   // ---------------- assertions ----------------
   // Observation state: armed by the first fault, edge count since fault clear.
   logic          primed;
   logic [CW-1:0] clean_edges;

   always_ff @(posedge clk_dom or posedge fault) begin
      if (fault) primed <= 1'b1;
   end

   always_ff @(posedge clk_dom or posedge fault) begin
      if (fault)                    clean_edges <= '0;
      else if (clean_edges < HOLD_C) clean_edges <= clean_edges + 1'b1;
   end

   // R1, R2, R3
   fault_forces_rst_chk: assert property (@(posedge clk_dom) disable iff (!primed)
      fault |-> rst_q);

   // R5, R6
   holdoff_rst_chk: assert property (@(posedge clk_dom) disable iff (!primed)
      (clean_edges < HOLD_C) |-> rst_q);

   // R5
   release_len_chk: assert property (@(posedge clk_dom) disable iff (!primed)
      $fell(rst_q) |-> (clean_edges == HOLD_C));

   // R7
   chain_clear_chk: assert property (@(posedge clk_dom) disable iff (!primed)
      !rst_q |-> (taps == '0));

endmodule

// File: tb/lockq_rst_gen_tb_top.sv
`timescale 1ns/100ps
module lockq_rst_gen_tb_top;

   localparam int N = 4;

   logic clk = 1'b0;
   logic clk_run = 1'b1;
   logic lock = 1'b1;
   logic stopped = 1'b0;
   logic req = 1'b0;
   logic rst;
   logic rdy;
   int   checks = 0;
   int   fails = 0;
   bit   done = 1'b0;

   // 250 MHz derived clock, can be halted
   always begin
      #2;
      if (clk_run) clk = ~clk;
   end

   lockq_rst_gen #(.HOLD_EDGES(N)) dut_i (
      .clk_dom       (clk),
      .lock_i        (lock),
      .clk_stopped_i (stopped),
      .ext_rst_req_i (req),
      .rst_dom_o     (rst),
      .dom_ready_o   (rdy)
   );

   // vector: {req, lock, stopped, edges[3:0], expected rst}
   localparam logic [7:0] VEC [9] = '{
      {1'b1, 1'b1, 1'b0, 4'd3, 1'b1},
      {1'b0, 1'b1, 1'b0, 4'd4, 1'b0},
      {1'b0, 1'b0, 1'b0, 4'd2, 1'b1},
      {1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
      {1'b0, 1'b1, 1'b0, 4'd1, 1'b0},
      {1'b0, 1'b1, 1'b1, 4'd5, 1'b1},
      {1'b0, 1'b1, 1'b0, 4'd4, 1'b0},
      {1'b1, 1'b0, 1'b1, 4'd2, 1'b1},
      {1'b0, 1'b1, 1'b0, 4'd4, 1'b0}
   };

   task automatic chk(input string req_tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req_tag, act, exp, $time);
      end
   endtask

   task automatic chk_rst(input string req_tag, input logic exp);
      chk(req_tag, rst, exp);
      chk({req_tag, " R7 ready"}, rdy, ~exp);
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #1 req = 1'b1;
      #0.1;
      chk_rst("R3 reset state", 1'b1);
      step(1);

      // vector table, R1 R2 R3 R5
      for (int v = 0; v < 9; v++) begin
         req     = VEC[v][7];
         lock    = VEC[v][6];
         stopped = VEC[v][5];
         step(int'(VEC[v][4:1]));
         chk_rst($sformatf("R1/R2/R3/R5 vector %0d", v), VEC[v][0]);
      end

      // R5: exact edge count
      req = 1'b1;
      step(1);
      req = 1'b0;
      for (int k = 1; k < N; k++) begin
         step(1);
         chk_rst($sformatf("R5 edge %0d", k), 1'b1);
      end
      step(1);
      chk_rst("R5 final edge", 1'b0);

      // R4: assertion in the same time step, no edge
      stopped = 1'b1;
      #0.1;
      chk_rst("R4 async stop", 1'b1);
      stopped = 1'b0;
      step(N);
      chk_rst("R4 release after stop", 1'b0);

      // R3: short request pulse, full hold-off
      req = 1'b1;
      #0.5 req = 1'b0;
      #0.1;
      chk_rst("R3 short pulse", 1'b1);
      step(N - 1);
      chk_rst("R3 hold after pulse", 1'b1);
      step(1);
      chk_rst("R3 release after pulse", 1'b0);

      // R6: fault pulse during hold-off restarts count
      req = 1'b1;
      step(1);
      req = 1'b0;
      step(2);
      lock = 1'b0;
      #0.5 lock = 1'b1;
      #0.1;
      chk_rst("R6 glitch asserts", 1'b1);
      step(N - 1);
      chk_rst("R6 still held", 1'b1);
      step(1);
      chk_rst("R6 release after restart", 1'b0);

      // R8 / R4: clock stopped
      clk_run = 1'b0;
      lock = 1'b0;
      #0.1;
      chk_rst("R4 async with clock stopped", 1'b1);
      #50 lock = 1'b1;
      #50;
      chk_rst("R8 held without clock", 1'b1);
      clk_run = 1'b1;
      step(N - 1);
      chk_rst("R8 held after restart", 1'b1);
      step(1);
      chk_rst("R8 release after clock returns", 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule